// File: doc/BRIEF.md
# Scan-Line-Locked Phase Clock Generator

This block turns a fast master clock into three slower phase clocks at one half, one quarter and one eighth of its rate. They are taken from the low bits of a free-running binary counter. The video timing logic holds the counter cleared until the first active video of a frame. Every scan line is a whole multiple of eight master cycles, so the phases stay aligned with the line from then on and the counter never needs clearing in the middle of a line.

The eighth-rate phase splits the shared memory bus between two owners. While it is high the processor drives the address and data buses. While it is low the video fetch uses them. Within the video half of each eight-cycle slot, the block decodes a pixel-data load strobe one master cycle wide. The strobe appears only while video is active and only in the single phase where both the quarter-rate and the half-rate clocks are high.

Top module: `vclk_gen`

## Requirements
- R1: While `hold_i` is high, the counter is cleared asynchronously, and all three phase clocks, `pix_load_o` and `cpu_bus_o` are low, regardless of `vid_active_i`.
- R2: After `hold_i` falls, the counter goes up by one on every rising master clock edge. After k edges it holds k modulo 8. `clk_half_o` is counter bit 0 and toggles on every edge.
- R3: `clk_quarter_o` is counter bit 1 and `clk_eighth_o` is counter bit 2. The first rising edge of `clk_eighth_o` follows the 4th master edge after release.
- R4: `cpu_bus_o` is high exactly when `clk_eighth_o` is high (the processor owns the bus). When it is low, the video fetch owns the bus.
- R5: `pix_load_o` is high exactly when `vid_active_i` is high and the counter is 3 (eighth low, quarter high, half high). It lasts one master cycle and never occurs while `clk_eighth_o` is high.
- R6: While `vid_active_i` is low, `pix_load_o` stays low in every phase.
- R7: With `vid_active_i` held high for one scan line of `LINE_LEN` (456) master cycles after release, exactly `LINE_LEN`/8 = 57 strobes occur, and all three phase clocks are low again at the line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| hold_i | input | 1 | Hold-clear request from video timing, active high, asynchronous |
| vid_active_i | input | 1 | High while the display is in its active region |
| clk_half_o | output | 1 | Master clock divided by 2 |
| clk_quarter_o | output | 1 | Master clock divided by 4 |
| clk_eighth_o | output | 1 | Master clock divided by 8; processor phase-2 and bus enable |
| pix_load_o | output | 1 | One-cycle pixel-data load strobe |
| cpu_bus_o | output | 1 | High when the processor owns the shared bus |

## Verification
The hardest condition to reach from the ports is phase lock across a full scan line. It only shows after hundreds of uninterrupted cycles following a single release of the hold. The stimulus releases the hold once, keeps video active for exactly 456 edges, counts every strobe, and then checks that all phases are back at zero. A vector table steps `vid_active_i` on and off across individual phases. Its entries place video-active high in phases other than 3 and low in phase 3, so both halves of the strobe qualification are exercised. A hold raised between clock edges then checks that the clear takes effect before the next edge.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
   localparam int unsigned PHASE_BITS  = 3;
   localparam int unsigned SLOT_CYCLES = 1 << PHASE_BITS;
   localparam logic [PHASE_BITS-1:0] LOAD_PHASE = 3'd3;

   typedef logic [PHASE_BITS-1:0] phase_t;

   function automatic logic is_load_phase(input phase_t p);
      return (p == LOAD_PHASE);
   endfunction
endpackage

// File: rtl/vclk_counter.sv
module vclk_counter
   import vclk_pkg::*;
#(
   parameter int unsigned W = PHASE_BITS
) (
   input  logic         clk_i,
   input  logic         hold_i,
   output logic [W-1:0] cnt_o
);
   generate
      if (W < PHASE_BITS) begin : g_bad_width
         $error("vclk_counter: W must be at least PHASE_BITS");
      end
   endgenerate

   always_ff @(posedge clk_i or posedge hold_i) begin
      if (hold_i) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end

   // R2: every released edge advances the count by one
   a_r2_increment: assert property (@(posedge clk_i) disable iff (hold_i)
      1'b1 |=> cnt_o == $past(cnt_o) + 1'b1);
   // R1: held counter sits at zero
   a_r1_held_zero: assert property (@(posedge clk_i)
      hold_i |-> cnt_o == '0);
endmodule

// File: rtl/vclk_strobe.sv
module vclk_strobe
   import vclk_pkg::*;
#(
   parameter bit REG_STROBE = 1'b0
) (
   input  logic   clk_i,
   input  logic   hold_i,
   input  phase_t phase_i,
   input  logic   vid_active_i,
   output logic   strobe_o
);
   generate
      if (REG_STROBE) begin : g_registered
         logic strobe_q;
         always_ff @(posedge clk_i or posedge hold_i) begin
            if (hold_i) strobe_q <= 1'b0;
            else        strobe_q <= vid_active_i && is_load_phase(phase_i + 1'b1);
         end
         assign strobe_o = strobe_q;
      end else begin : g_decoded
         assign strobe_o = vid_active_i && !hold_i && is_load_phase(phase_i);
         // R6: no strobe without video active
         a_r6_no_active_no_load: assert property (@(posedge clk_i)
            !vid_active_i |-> !strobe_o);
      end
   endgenerate

   // R5: strobe is a single cycle
   a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (hold_i)
      strobe_o |=> !strobe_o);
endmodule

// File: rtl/vclk_gen.sv
module vclk_gen
   import vclk_pkg::*;
#(
   parameter int unsigned LINE_LEN   = 456,
   parameter bit          REG_STROBE = 1'b0
) (
   input  logic clk_i,
   input  logic hold_i,
   input  logic vid_active_i,
   output logic clk_half_o,
   output logic clk_quarter_o,
   output logic clk_eighth_o,
   output logic pix_load_o,
   output logic cpu_bus_o
);
   localparam int unsigned POS_W = $clog2(LINE_LEN);

   generate
      if (LINE_LEN % SLOT_CYCLES != 0) begin : g_bad_line
         $error("vclk_gen: LINE_LEN must be a multiple of the eighth-rate period");
      end
      if (LINE_LEN < SLOT_CYCLES) begin : g_short_line
         $error("vclk_gen: LINE_LEN shorter than one bus slot");
      end
   endgenerate

   phase_t phase;

   vclk_counter #(.W(PHASE_BITS)) u_cnt (
      .clk_i  (clk_i),
      .hold_i (hold_i),
      .cnt_o  (phase)
   );

   vclk_strobe #(.REG_STROBE(REG_STROBE)) u_strb (
      .clk_i        (clk_i),
      .hold_i       (hold_i),
      .phase_i      (phase),
      .vid_active_i (vid_active_i),
      .strobe_o     (pix_load_o)
   );

   assign clk_half_o    = phase[0];
   assign clk_quarter_o = phase[1];
   assign clk_eighth_o  = phase[2];
   assign cpu_bus_o     = phase[2];

   // Line-position tracker used only by the lock assertion
   logic [POS_W-1:0] line_pos;
   always_ff @(posedge clk_i or posedge hold_i) begin
      if (hold_i)                           line_pos <= '0;
      else if (line_pos == POS_W'(LINE_LEN - 1)) line_pos <= '0;
      else                                  line_pos <= line_pos + 1'b1;
   end

   // R7: phases are back at zero on every line boundary
   a_r7_line_lock: assert property (@(posedge clk_i) disable iff (hold_i)
      line_pos == '0 |-> !clk_half_o && !clk_quarter_o && !clk_eighth_o);
   // R5: strobe only in video-owned slot with quarter and half high
   a_r5_load_window: assert property (@(posedge clk_i) disable iff (hold_i)
      pix_load_o |-> !clk_eighth_o && clk_quarter_o && clk_half_o);
   // R3: quarter clock changes when half clock falls
   a_r3_quarter_step: assert property (@(posedge clk_i) disable iff (hold_i)
      $fell(clk_half_o) |-> clk_quarter_o != $past(clk_quarter_o));
   // R2: half clock toggles each edge
   a_r2_half_toggle: assert property (@(posedge clk_i) disable iff (hold_i)
      1'b1 |=> clk_half_o != $past(clk_half_o));
   // R1: held outputs quiet
   a_r1_outputs_quiet: assert property (@(posedge clk_i)
      hold_i |-> !pix_load_o && !cpu_bus_o && !clk_eighth_o);
endmodule

// File: tb/sim_vclk_gen.sv
`timescale 1ns/1ps
module sim_vclk_gen;
   logic clk = 1'b0;
   logic hold, vact;
   logic half, quarter, eighth, load, cpu;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vclk_gen u0 (
      .clk_i(clk), .hold_i(hold), .vid_active_i(vact),
      .clk_half_o(half), .clk_quarter_o(quarter), .clk_eighth_o(eighth),
      .pix_load_o(load), .cpu_bus_o(cpu)
   );

   // {vact, expected count[2:0], expected strobe}, entry i follows edge i+1 after release
   localparam int NVEC = 19;
   localparam logic [4:0] VEC [NVEC] = '{
      {1'b1,3'd1,1'b0}, {1'b1,3'd2,1'b0}, {1'b1,3'd3,1'b1}, {1'b1,3'd4,1'b0},
      {1'b1,3'd5,1'b0}, {1'b0,3'd6,1'b0}, {1'b1,3'd7,1'b0}, {1'b1,3'd0,1'b0},
      {1'b0,3'd1,1'b0}, {1'b0,3'd2,1'b0}, {1'b0,3'd3,1'b0}, {1'b1,3'd4,1'b0},
      {1'b1,3'd5,1'b0}, {1'b0,3'd6,1'b0}, {1'b1,3'd7,1'b0}, {1'b1,3'd0,1'b0},
      {1'b1,3'd1,1'b0}, {1'b1,3'd2,1'b0}, {1'b1,3'd3,1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int strobes;
      int prev;
      int widths_bad;
      hold = 1'b1;
      vact = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state with video active
      check("R1 held outputs", {27'd0, half, quarter, eighth, load, cpu}, 32'd0);

      // vector walk
      hold = 1'b0;
      for (int i = 0; i < NVEC; i++) begin
         @(posedge clk);
         #1 vact = VEC[i][4];
         #1;
         check(VEC[i][0] ? "R5 strobe phase" : "R2/R3/R6 phase",
               {27'd0, eighth, quarter, half, load, cpu},
               {27'd0, VEC[i][3:1], VEC[i][0], VEC[i][3]});
      end

      // R4: bus owner follows eighth clock over a slot
      for (int i = 0; i < 8; i++) begin
         @(posedge clk);
         #1 check("R4 bus owner", {31'd0, cpu}, {31'd0, eighth});
      end

      // R1: asynchronous clear between edges
      @(posedge clk);
      #1 hold = 1'b1;
      #0.5 check("R1 async clear", {28'd0, half, quarter, eighth, cpu}, 32'd0);
      repeat (5) @(posedge clk);
      #1 check("R1 hold blocks strobe", {31'd0, load}, 32'd0);

      // R6: full slot with video inactive
      hold = 1'b0;
      vact = 1'b0;
      strobes = 0;
      for (int i = 0; i < 16; i++) begin
         @(posedge clk);
         #1 if (load) strobes++;
      end
      check("R6 no strobes inactive", strobes, 0);

      // R3: first eighth rise after 4 edges from release
      hold = 1'b1;
      @(posedge clk);
      #1 hold = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R3 eighth low after 3", {31'd0, eighth}, 32'd0);
      @(posedge clk);
      #1 check("R3 eighth high after 4", {31'd0, eighth}, 32'd1);

      // R7: one full line with video active
      hold = 1'b1;
      vact = 1'b1;
      @(posedge clk);
      #1 hold = 1'b0;
      strobes = 0;
      prev = 0;
      widths_bad = 0;
      for (int i = 0; i < 456; i++) begin
         @(posedge clk);
         #1;
         if (load) strobes++;
         if (load && prev == 1) widths_bad++;
         prev = int'(load);
      end
      check("R7 strobes per line", strobes, 57);
      check("R5 strobe width", widths_bad, 0);
      check("R7 phases at line end", {29'd0, eighth, quarter, half}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule